// File: doc/BRIEF.md
# Flash Word-Program Sequencer

This block sits between the CPU's flash write path and the flash macro. It turns CPU data writes into 128-bit word-program operations and drives the macro through a start/done handshake. It selects the bank from the top address bit and can wrap each program in a verify pass before it, after it, or both. A small control and status register sets the write mode, the verify options and the master enable. The same register reports whether an operation is pending or running and on which bank.

There are two write modes. In immediate mode, each accepted 32-bit write becomes one program operation at once. The written lane carries the data and the other three lanes are all ones, so the cells behind them are left as they are. In full-word mode, four 32-bit writes are gathered into one 128-bit word. They must arrive lowest lane first, all within one 128-bit line, and the program starts only when the top lane lands. A write that breaks that order is refused. Verify failures and refused sequences raise sticky flags that software clears by writing ones. While a low-frequency mode is signalled, the master enable is held at zero.

Top module: `fwp_seq`

## Requirements
- R1: After reset the control word (reg_sel=0) reads 0x0000000C (enable 0 in bit 0, immediate mode 0 in bit 1, pre-verify 1 in bit 2, post-verify 1 in bit 3), and the flag word (reg_sel=1) reads 0.
- R2: Status bits [17:16] read 00 when idle, 01 for exactly the one cycle after a write is accepted, and 10 from the cycle the start strobe is issued until the operation ends; 11 is never produced. Bit 18 shows the active bank (0 or 1) while the status is not idle.
- R3: Writes to control bits [3:0] are ignored while the status is not idle.
- R4: While lf_mode is high, the enable bit reads 0 and writing 1 to it has no effect.
- R5: While enable is 0, flash writes start no operation.
- R6: In immediate mode (bit 1 = 0), each accepted write programs line fw_waddr[AW-1:2] on bank fw_waddr[AW-1]. The data sits in lane fw_waddr[1:0] (bits 32*lane+31..32*lane) and all other bits are 1.
- R7: In full-word mode (bit 1 = 1), writes to lanes 0, 1, 2 and 3 of one line, in that order, start one program carrying the four words in their lanes; the first three leave the status idle.
- R8: In full-word mode, a write to the wrong lane or, after lane 0, to another line discards the partial word, issues no program and sets sticky flag bit 1 of the flag word; writing 1 to that bit clears it.
- R9: Steps run in the order pre-verify (fm_op 01, if bit 2 is set), program (fm_op 00), post-verify (fm_op 10, if bit 3 is set). Each step's fm_start is a one-cycle pulse, and the next step's pulse comes the cycle after fm_done.
- R10: fm_vpass low with fm_done on a verify step ends the operation: the status returns to idle at once, no later step starts, and sticky flag bit 0 is set. Writing 1 to it clears it; writing 0 leaves it.
- R11: Control-word bits 31..19 and 15..4 read 0. Flash writes that arrive while the status is not idle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control/status word, 1 the flag word |
| reg_wdata | input | 4 | Write data for the writable low bits |
| reg_rdata | output | 32 | Read data of the selected word |
| lf_mode | input | 1 | Low-frequency mode active; holds enable at 0 |
| fw_valid | input | 1 | CPU write to flash this cycle |
| fw_waddr | input | AW | 32-bit word address of the flash write |
| fw_wdata | input | 32 | Flash write data |
| fm_start | output | 1 | One-cycle start strobe to the flash macro |
| fm_op | output | 2 | Step kind: 00 program, 01 pre-verify, 10 post-verify |
| fm_line | output | AW-2 | 128-bit line address of the operation |
| fm_bank | output | 1 | Bank of the operation |
| fm_wdata | output | 128 | Word to program or verify |
| fm_done | input | 1 | Flash macro step complete |
| fm_vpass | input | 1 | Verify result, valid with fm_done |

## Verification
A wrong sequencer state shows within one cycle as a status code out of step with fm_start. It can also show as a strobe lasting two cycles or a verify step running out of order. The bench watches all three at every step. A collector that counts lanes wrongly shows as a program starting after three writes, or not after four, or as bad lane placement in fm_wdata on the program step. A missed lock or enable override shows at the next readback of the control word. Sweeping every lane, bank and verify combination makes each slip visible within one operation.

// File: rtl/fwp_pkg.sv
// Shared types for the flash word-program sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package fwp_pkg;
    // Sequencer phases.
    typedef enum logic [1:0] {
        EN_IDLE = 2'b00,
        EN_PEND = 2'b01,
        EN_GO   = 2'b10,
        EN_WAIT = 2'b11
    } eng_state_t;

    // Step kind presented to the flash macro.
    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_VPRE = 2'b01,
        OP_VPST = 2'b10
    } flash_op_t;

    // Status codes reported in the control word.
    localparam logic [1:0] ST_IDLE = 2'b00;
    localparam logic [1:0] ST_PEND = 2'b01;
    localparam logic [1:0] ST_BUSY = 2'b10;
endpackage

// File: rtl/fwp_regs.sv
// Control/status register bank.
// Holds enable, mode and the two verify options, locked unless the status is
// idle (the unused code 11 counts as idle). lf_mode holds enable at zero.
// Keeps the two sticky flags, cleared by writing ones. Reads are combinational.
module fwp_regs
    import fwp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [3:0]  reg_wdata,
    input  logic        lf_mode,
    input  logic [1:0]  st_code,
    input  logic        bank_act,
    input  logic        vfail_set,
    input  logic        oerr_set,
    output logic        cfg_en,
    output logic        cfg_mode,
    output logic        cfg_pre,
    output logic        cfg_pst,
    output logic [31:0] reg_rdata
);
    logic idle;
    logic ctl_wr;
    logic flg_wr;
    logic vfail_q;
    logic oerr_q;

    assign idle   = (st_code == ST_IDLE) || (st_code == 2'b11);
    assign ctl_wr = reg_wr && !reg_sel && idle;
    assign flg_wr = reg_wr && reg_sel;

    // Purpose: control bits with lock and low-frequency override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_mode <= 1'b0;
            cfg_pre  <= 1'b1;
            cfg_pst  <= 1'b1;
        end else begin
            if (lf_mode) begin
                cfg_en <= 1'b0;
            end else if (ctl_wr) begin
                cfg_en <= reg_wdata[0];
            end
            if (ctl_wr) begin
                cfg_mode <= reg_wdata[1];
                cfg_pre  <= reg_wdata[2];
                cfg_pst  <= reg_wdata[3];
            end
        end
    end

    // Purpose: sticky flags; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vfail_q <= 1'b0;
            oerr_q  <= 1'b0;
        end else begin
            vfail_q <= vfail_set || (vfail_q && !(flg_wr && reg_wdata[0]));
            oerr_q  <= oerr_set  || (oerr_q  && !(flg_wr && reg_wdata[1]));
        end
    end

    // Purpose: read mux; reserved bits stay zero, bank shown only when active.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[0] = vfail_q;
            reg_rdata[1] = oerr_q;
        end else begin
            reg_rdata[0]     = cfg_en;
            reg_rdata[1]     = cfg_mode;
            reg_rdata[2]     = cfg_pre;
            reg_rdata[3]     = cfg_pst;
            reg_rdata[17:16] = st_code;
            reg_rdata[18]    = bank_act && !idle;
        end
    end
endmodule

// File: rtl/fwp_collect.sv
// Write collector.
// Immediate mode: every accepted write launches a word with one lane filled
// and all other bits one. Full-word mode: lanes must come lowest first within
// one line; the top lane launches the merged word and any break refuses the
// write and discards the partial word. Assumes wr_ok already covers enable
// and the idle status.
module fwp_collect #(
    parameter int AW = 20,
    parameter int DW = 32,
    parameter int WW = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_ok,
    input  logic                         mode_full,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DW-1:0]                wr_data,
    output logic                         launch,
    output logic [AW-$clog2(WW/DW)-1:0]  launch_line,
    output logic [WW-1:0]                launch_data,
    output logic                         order_err
);
    localparam int LANES = WW / DW;
    localparam int BW    = $clog2(LANES);
    localparam int LW    = AW - BW;

    logic [BW-1:0] beat;
    logic [BW-1:0] cnt_q;
    logic [LW-1:0] line;
    logic [LW-1:0] line_q;
    logic [WW-1:0] acc_q;
    logic [WW-1:0] merged;
    logic [WW-1:0] filled;
    logic          hit;
    logic          last;

    assign beat = wr_addr[BW-1:0];
    assign line = wr_addr[AW-1:BW];

    // Purpose: place the write data in its lane for both modes.
    always_comb begin
        filled = '1;
        merged = acc_q;
        for (int i = 0; i < LANES; i++) begin
            if (beat == BW'(i)) begin
                filled[i*DW +: DW] = wr_data;
                merged[i*DW +: DW] = wr_data;
            end
        end
    end

    // Purpose: order check and launch decision.
    always_comb begin
        hit         = wr_ok && mode_full && (beat == cnt_q)
                      && ((cnt_q == '0) || (line == line_q));
        last        = (cnt_q == BW'(LANES - 1));
        launch      = wr_ok && (mode_full ? (hit && last) : 1'b1);
        order_err   = wr_ok && mode_full && !hit;
        launch_line = line;
        launch_data = mode_full ? merged : filled;
    end

    // Purpose: partial-word state; cleared outside full-word mode or on error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            line_q <= '0;
            acc_q  <= '0;
        end else if (!mode_full || order_err) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q  <= last ? '0 : cnt_q + 1'b1;
            line_q <= line;
            acc_q  <= merged;
        end
    end
endmodule

// File: rtl/fwp_engine.sv
// Step sequencer.
// Takes one launched word, waits one pending cycle, then runs pre-verify,
// program and post-verify as enabled. Each step is a one-cycle start and a
// wait for done. A failing verify aborts at once. Assumes launch only comes
// while idle.
module fwp_engine
    import fwp_pkg::*;
#(
    parameter int LW = 18,
    parameter int WW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [LW-1:0] launch_line,
    input  logic [WW-1:0] launch_data,
    input  logic          cfg_pre,
    input  logic          cfg_pst,
    input  logic          fm_done,
    input  logic          fm_vpass,
    output logic          fm_start,
    output logic [1:0]    fm_op,
    output logic [LW-1:0] fm_line,
    output logic          fm_bank,
    output logic [WW-1:0] fm_wdata,
    output logic [1:0]    st_code,
    output logic          vfail_set
);
    eng_state_t state_q;
    flash_op_t  step_q;
    logic       pre_q;
    logic       pst_q;
    logic       is_verify;

    assign is_verify = (step_q != OP_PROG);
    assign vfail_set = (state_q == EN_WAIT) && fm_done && is_verify && !fm_vpass;

    // Purpose: phase and step progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EN_IDLE;
            step_q  <= OP_PROG;
            pre_q   <= 1'b0;
            pst_q   <= 1'b0;
        end else begin
            case (state_q)
                EN_IDLE: if (launch) begin
                    state_q <= EN_PEND;
                    pre_q   <= cfg_pre;
                    pst_q   <= cfg_pst;
                end
                EN_PEND: begin
                    state_q <= EN_GO;
                    step_q  <= pre_q ? OP_VPRE : OP_PROG;
                end
                EN_GO:   state_q <= EN_WAIT;
                EN_WAIT: if (fm_done) begin
                    if (vfail_set) begin
                        state_q <= EN_IDLE;
                    end else begin
                        case (step_q)
                            OP_VPRE: begin
                                step_q  <= OP_PROG;
                                state_q <= EN_GO;
                            end
                            OP_PROG: begin
                                if (pst_q) begin
                                    step_q  <= OP_VPST;
                                    state_q <= EN_GO;
                                end else begin
                                    state_q <= EN_IDLE;
                                end
                            end
                            default: state_q <= EN_IDLE;
                        endcase
                    end
                end
                default: state_q <= EN_IDLE;
            endcase
        end
    end

    // Purpose: capture the word, line and bank when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fm_line  <= '0;
            fm_bank  <= 1'b0;
            fm_wdata <= '0;
        end else if (state_q == EN_IDLE && launch) begin
            fm_line  <= launch_line;
            fm_bank  <= launch_line[LW-1];
            fm_wdata <= launch_data;
        end
    end

    // Purpose: strobe, step code and status code from the phase.
    always_comb begin
        fm_start = (state_q == EN_GO);
        fm_op    = step_q;
        case (state_q)
            EN_IDLE: st_code = ST_IDLE;
            EN_PEND: st_code = ST_PEND;
            default: st_code = ST_BUSY;
        endcase
    end
endmodule

// File: rtl/fwp_seq.sv
// Top of the flash word-program sequencer.
// Wires the register bank, the write collector and the step sequencer.
// A flash write is accepted only while enabled and idle; others are dropped.
module fwp_seq #(
    parameter int AW = 20,
    parameter int DW = 32,
    parameter int WW = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_sel,
    input  logic [3:0]                  reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic                        lf_mode,
    input  logic                        fw_valid,
    input  logic [AW-1:0]               fw_waddr,
    input  logic [DW-1:0]               fw_wdata,
    output logic                        fm_start,
    output logic [1:0]                  fm_op,
    output logic [AW-$clog2(WW/DW)-1:0] fm_line,
    output logic                        fm_bank,
    output logic [WW-1:0]               fm_wdata,
    input  logic                        fm_done,
    input  logic                        fm_vpass
);
    localparam int LW = AW - $clog2(WW / DW);

    logic          cfg_en;
    logic          cfg_mode;
    logic          cfg_pre;
    logic          cfg_pst;
    logic [1:0]    st_code;
    logic          vfail_set;
    logic          oerr_set;
    logic          wr_ok;
    logic          launch;
    logic [LW-1:0] launch_line;
    logic [WW-1:0] launch_data;

    assign wr_ok = fw_valid && cfg_en && (st_code == fwp_pkg::ST_IDLE);

    fwp_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .lf_mode   (lf_mode),
        .st_code   (st_code),
        .bank_act  (fm_bank),
        .vfail_set (vfail_set),
        .oerr_set  (oerr_set),
        .cfg_en    (cfg_en),
        .cfg_mode  (cfg_mode),
        .cfg_pre   (cfg_pre),
        .cfg_pst   (cfg_pst),
        .reg_rdata (reg_rdata)
    );

    fwp_collect #(.AW(AW), .DW(DW), .WW(WW)) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ok       (wr_ok),
        .mode_full   (cfg_mode && cfg_en),
        .wr_addr     (fw_waddr),
        .wr_data     (fw_wdata),
        .launch      (launch),
        .launch_line (launch_line),
        .launch_data (launch_data),
        .order_err   (oerr_set)
    );

    fwp_engine #(.LW(LW), .WW(WW)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_line (launch_line),
        .launch_data (launch_data),
        .cfg_pre     (cfg_pre),
        .cfg_pst     (cfg_pst),
        .fm_done     (fm_done),
        .fm_vpass    (fm_vpass),
        .fm_start    (fm_start),
        .fm_op       (fm_op),
        .fm_line     (fm_line),
        .fm_bank     (fm_bank),
        .fm_wdata    (fm_wdata),
        .st_code     (st_code),
        .vfail_set   (vfail_set)
    );
endmodule

// File: rtl/fwp_seq_chk.sv
// Property checker for fwp_seq, attached by the bind at the end of this file.
// Relates the register view, the status code and the flash strobe over time.
module fwp_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lf_mode,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] reg_rdata,
    input logic        fm_start,
    input logic [1:0]  st_code,
    input logic        cfg_en,
    input logic        cfg_mode,
    input logic        cfg_pre,
    input logic        cfg_pst
);
    p_pend_then_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_code == 2'b01 |=> (st_code == 2'b10 && fm_start));

    p_no_code3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_code != 2'b11);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fm_start |-> st_code == 2'b10);

    p_ctl_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code != 2'b00 && reg_wr && !reg_sel) |=> $stable({cfg_mode, cfg_pre, cfg_pst}));

    p_lf_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lf_mode |=> !cfg_en);

    p_no_launch_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code == 2'b00 && !cfg_en) |=> st_code != 2'b01);

    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fm_start |=> !fm_start);

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[31:19] == '0 && reg_rdata[15:4] == '0));
endmodule

bind fwp_seq fwp_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lf_mode   (lf_mode),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .fm_start  (fm_start),
    .st_code   (st_code),
    .cfg_en    (cfg_en),
    .cfg_mode  (cfg_mode),
    .cfg_pre   (cfg_pre),
    .cfg_pst   (cfg_pst)
);

// File: tb/sim_fwp_seq.sv
// Self-checking bench: sweeps lanes, banks and verify options in both modes,
// plus lock, low-frequency, ordering and verify-failure cases.
module sim_fwp_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_sel = 1'b0;
    logic [3:0]   reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         lf_mode = 1'b0;
    logic         fw_valid = 1'b0;
    logic [19:0]  fw_waddr = '0;
    logic [31:0]  fw_wdata = '0;
    logic         fm_start;
    logic [1:0]   fm_op;
    logic [17:0]  fm_line;
    logic         fm_bank;
    logic [127:0] fm_wdata;
    logic         fm_done = 1'b0;
    logic         fm_vpass = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fwp_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lf_mode(lf_mode),
        .fw_valid(fw_valid), .fw_waddr(fw_waddr), .fw_wdata(fw_wdata),
        .fm_start(fm_start), .fm_op(fm_op), .fm_line(fm_line), .fm_bank(fm_bank),
        .fm_wdata(fm_wdata), .fm_done(fm_done), .fm_vpass(fm_vpass)
    );

    task automatic chk_eq(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic regw(input logic sel, input logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic rd_flags(output logic [31:0] v);
        reg_sel = 1'b1;
        #1 v = reg_rdata;
        reg_sel = 1'b0;
        #1;
    endtask

    task automatic fwr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        fw_valid = 1'b1; fw_waddr = a; fw_wdata = d;
        @(negedge clk);
        fw_valid = 1'b0;
    endtask

    // One step: strobe seen at this negedge, done answered in the wait phase.
    task automatic serve(input logic [1:0] op, input logic vp, input string req,
                         input logic [17:0] line, input logic [127:0] data);
        chk_eq("R9 start strobe", {127'b0, fm_start}, 128'd1);
        chk_eq("R9 step order", {126'b0, fm_op}, {126'b0, op});
        chk_eq("R2 busy during step", {126'b0, reg_rdata[17:16]}, 128'd2);
        if (op == 2'b00) begin
            chk_eq({req, " word"}, fm_wdata, data);
            chk_eq({req, " line"}, {110'b0, fm_line}, {110'b0, line});
            chk_eq({req, " bank"}, {127'b0, fm_bank}, {127'b0, line[17]});
        end
        @(negedge clk);
        chk_eq("R9 one-cycle strobe", {127'b0, fm_start}, 128'd0);
        fm_done = 1'b1; fm_vpass = vp;
        @(negedge clk);
        fm_done = 1'b0; fm_vpass = 1'b1;
    endtask

    // Full operation after the launching write; fail: 0 none, 1 pre, 2 post.
    task automatic run_op(input logic pre, input logic pst, input int fail, input string req,
                          input logic [17:0] line, input logic [127:0] data);
        logic [31:0] fl;
        chk_eq("R2 pending status", {126'b0, reg_rdata[17:16]}, 128'd1);
        chk_eq("R2 active bank", {127'b0, reg_rdata[18]}, {127'b0, line[17]});
        @(negedge clk);
        if (pre) begin
            serve(2'b01, fail != 1, req, line, data);
            if (fail == 1) begin
                chk_eq("R10 idle after pre fail", {126'b0, reg_rdata[17:16]}, 128'd0);
                chk_eq("R10 no program after fail", {127'b0, fm_start}, 128'd0);
                rd_flags(fl);
                chk_eq("R10 fail flag", {96'b0, fl}, 128'd1);
                return;
            end
        end
        serve(2'b00, 1'b1, req, line, data);
        if (pst) begin
            serve(2'b10, fail != 2, req, line, data);
            if (fail == 2) begin
                rd_flags(fl);
                chk_eq("R10 fail flag post", {96'b0, fl}, 128'd1);
            end
        end
        chk_eq("R2 idle at end", {126'b0, reg_rdata[17:16]}, 128'd0);
        chk_eq("R2 no strobe at end", {127'b0, fm_start}, 128'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0]  fl;
        logic [127:0] exp;
        logic [19:0]  a;
        logic [31:0]  d;
        logic [17:0]  ln;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values, R11 reserved bits
        chk_eq("R1 control reset", {96'b0, reg_rdata}, 128'h0000000C);
        rd_flags(fl);
        chk_eq("R1 flags reset", {96'b0, fl}, 128'd0);
        chk_eq("R11 reserved zero", {96'b0, reg_rdata & 32'hFFF8FFF0}, 128'd0);

        // R5: disabled, write starts nothing
        fwr(20'h00010, 32'h1234);
        chk_eq("R5 no pending when disabled", {126'b0, reg_rdata[17:16]}, 128'd0);
        @(negedge clk);
        chk_eq("R5 no strobe when disabled", {127'b0, fm_start}, 128'd0);

        // R6 sweep: verify options x bank x lane, immediate mode
        for (int c = 0; c < 4; c++) begin
            regw(1'b0, {c[1], c[0], 1'b0, 1'b1});
            for (int b = 0; b < 2; b++) begin
                for (int l = 0; l < 4; l++) begin
                    a   = {b[0], 17'(c * 8 + l + 3), l[1:0]};
                    d   = 32'hC0DE0000 ^ (c << 12) ^ (b << 8) ^ (l * 32'h01010101);
                    exp = '1;
                    exp[l*32 +: 32] = d;
                    fwr(a, d);
                    run_op(c[0], c[1], 0, "R6 immediate", a[19:2], exp);
                end
            end
        end

        // R3 lock and R11 dropped write during an operation
        regw(1'b0, 4'b0101);
        fwr(20'h00A04, 32'h55AA55AA);
        @(negedge clk);
        chk_eq("R3 pre strobe", {127'b0, fm_start}, 128'd1);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 4'b1110;
        fw_valid = 1'b1; fw_waddr = 20'h8FFF0; fw_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0; fw_valid = 1'b0;
        chk_eq("R3 control locked", {124'b0, reg_rdata[3:0]}, 128'h5);
        chk_eq("R11 reserved zero busy", {96'b0, reg_rdata & 32'hFFF8FFF0}, 128'd0);
        fm_done = 1'b1;
        @(negedge clk);
        fm_done = 1'b0;
        exp = '1; exp[31:0] = 32'h55AA55AA;
        serve(2'b00, 1'b1, "R3 program after lock", 18'h00281, exp);
        chk_eq("R3 idle after op", {126'b0, reg_rdata[17:16]}, 128'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk_eq("R11 dropped write no start", {127'b0, fm_start}, 128'd0);
        end
        chk_eq("R3 control kept", {124'b0, reg_rdata[3:0]}, 128'h5);

        // R4 low-frequency override
        lf_mode = 1'b1;
        @(negedge clk);
        chk_eq("R4 enable forced low", {127'b0, reg_rdata[0]}, 128'd0);
        regw(1'b0, 4'b0001);
        chk_eq("R4 enable write ignored", {127'b0, reg_rdata[0]}, 128'd0);
        fwr(20'h00100, 32'h1);
        chk_eq("R4 no launch in lf", {126'b0, reg_rdata[17:16]}, 128'd0);
        lf_mode = 1'b0;
        regw(1'b0, 4'b0001);
        chk_eq("R4 enable after lf", {127'b0, reg_rdata[0]}, 128'd1);

        // R7 full-word collection over banks and lines
        regw(1'b0, 4'b1011);
        for (int b = 0; b < 2; b++) begin
            for (int m = 0; m < 3; m++) begin
                ln = {b[0], 17'(m * 5 + 1)};
                for (int l = 0; l < 4; l++) begin
                    d = 32'hF00D0000 ^ (b << 10) ^ (m << 6) ^ l;
                    exp[l*32 +: 32] = d;
                    fwr({ln, l[1:0]}, d);
                    if (l < 3)
                        chk_eq("R7 idle while collecting", {126'b0, reg_rdata[17:16]}, 128'd0);
                end
                run_op(1'b0, 1'b1, 0, "R7 full word", ln, exp);
            end
        end

        // R8 wrong lane, then wrong line
        fwr({18'h00040, 2'd0}, 32'h0);
        fwr({18'h00040, 2'd2}, 32'h2);
        chk_eq("R8 no launch on wrong lane", {126'b0, reg_rdata[17:16]}, 128'd0);
        rd_flags(fl);
        chk_eq("R8 order flag", {96'b0, fl}, 128'd2);
        regw(1'b1, 4'b0010);
        rd_flags(fl);
        chk_eq("R8 order flag cleared", {96'b0, fl}, 128'd0);
        fwr({18'h00041, 2'd0}, 32'h10);
        fwr({18'h00042, 2'd1}, 32'h11);
        fwr({18'h00042, 2'd2}, 32'h12);
        fwr({18'h00042, 2'd3}, 32'h13);
        chk_eq("R8 no launch after wrong line", {126'b0, reg_rdata[17:16]}, 128'd0);
        @(negedge clk);
        chk_eq("R8 no strobe", {127'b0, fm_start}, 128'd0);
        rd_flags(fl);
        chk_eq("R8 order flag line", {96'b0, fl}, 128'd2);
        regw(1'b1, 4'b0010);

        // R10 verify failure on pre step, flag clears only on write of one
        regw(1'b0, 4'b1101);
        fwr(20'h00200, 32'hDEAD);
        exp = '1; exp[31:0] = 32'hDEAD;
        run_op(1'b1, 1'b1, 1, "R10 pre fail", 18'h00080, exp);
        regw(1'b1, 4'b0000);
        rd_flags(fl);
        chk_eq("R10 zero write keeps flag", {96'b0, fl}, 128'd1);
        regw(1'b1, 4'b0001);
        rd_flags(fl);
        chk_eq("R10 flag cleared", {96'b0, fl}, 128'd0);
        fwr(20'h80207, 32'hBEEF);
        exp = '1; exp[127:96] = 32'hBEEF;
        run_op(1'b1, 1'b1, 2, "R10 post fail", 18'h20081, exp);
        chk_eq("R10 idle after post fail", {126'b0, reg_rdata[17:16]}, 128'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule